// File: doc/BRIEF.md
# Short Conditional Branch Resolver

This unit decides the outcome of a short relative conditional branch once the decoder has the opcode, its one-byte signed displacement and the machine state in hand. It reads the carry, zero, sign and overflow flags (or the count register for the count-zero form), forms the branch target from the current instruction pointer, trims it to the operand size in force, and tests it against either the code-segment limit or the canonical address rule, depending on the operating mode.

Each accepted request produces one registered result a cycle later: a taken indication, the pointer to continue from, and at most one fault (invalid opcode or general protection). Opcodes in the short-conditional range that this unit does not evaluate are reported on a separate output and never branch. The caller supplies the fall-through pointer as the current pointer, so a not-taken or faulting branch simply hands that value back.

Top module: `cbr_unit`

## Requirements
- R1: Unsigned and equality conditions: opcode 0x72 branches when carry=1, 0x73 when carry=0, 0x74 when zero=1, 0x75 when zero=0, 0x76 when carry=1 or zero=1, 0x77 when carry=0 and zero=0.
- R2: Signed conditions: 0x7C branches when sign differs from overflow, 0x7D when they are equal, 0x7E when zero=1 or sign differs from overflow, 0x7F when zero=0 and sign equals overflow.
- R3: Opcode 0xE3 ignores the flags and branches when the count register is zero over the width picked by `addrSize` (0 = low 16 bits, 1 = low 32 bits, 2 = all 64 bits).
- R4: Opcode 0xE3 raises `faultUd` when `longMode`=1 with `addrSize`=0, or when `longMode`=0 with `addrSize`=2.
- R5: A taken branch reports `nextIp` equal to `curIp` plus the displacement sign-extended to 64 bits.
- R6: Outside 64-bit mode with `opSize`=0 (16 bits) the target keeps only its low 16 bits before any check; with `longMode`=1 the operand size is treated as 64 and no trimming occurs.
- R7: Outside 64-bit mode a branch whose condition holds and whose target is above `csLimit` raises `faultGp`, is not taken and returns `nextIp` = `curIp`; a target equal to the limit is taken.
- R8: In 64-bit mode a branch whose condition holds and whose target has bits 63..47 not all equal raises `faultGp` and is not taken.
- R9: `lockPrefix` with any evaluated opcode raises `faultUd` in every mode; `faultUd` wins over `faultGp`, and no fault ever coexists with `taken`.
- R10: When the condition is false no target check is made: no fault, `taken`=0 and `nextIp` = `curIp`.
- R11: Opcodes other than 0x72..0x77, 0x7C..0x7F and 0xE3 set `unsupported`, with `taken`, `faultUd` and `faultGp` all low.
- R12: Results appear with `outValid` exactly one clock after `inValid`; when `outValid` is low, `taken`, both faults and `unsupported` are low, and all of them are low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request present this cycle |
| opcode | input | 8 | Branch opcode byte |
| disp | input | 8 | Signed displacement |
| curIp | input | 64 | Fall-through instruction pointer |
| flagCarry | input | 1 | Carry flag |
| flagZero | input | 1 | Zero flag |
| flagSign | input | 1 | Sign flag |
| flagOverflow | input | 1 | Overflow flag |
| countReg | input | 64 | Count register value |
| longMode | input | 1 | 1 = 64-bit mode |
| opSize | input | 2 | Operand size: 0 = 16, 1 = 32, 2 = 64 |
| addrSize | input | 2 | Address size: 0 = 16, 1 = 32, 2 = 64 |
| csLimit | input | 32 | Code-segment limit (inclusive) |
| lockPrefix | input | 1 | Lock prefix present |
| outValid | output | 1 | Result valid |
| taken | output | 1 | Branch taken |
| nextIp | output | 64 | Pointer to continue from |
| faultUd | output | 1 | Invalid-opcode fault |
| faultGp | output | 1 | General-protection fault |
| unsupported | output | 1 | Opcode not evaluated by this unit |

## Verification
Each condition opcode is driven with flag sets on both sides of its predicate, so a swapped flag or inverted sense shows as a wrong `taken`. The count form is tried with values whose only nonzero bit lies just above 16 or 32 bits, separating the three address widths. Targets are placed exactly at and one past the segment limit, across a 16-bit wrap, and across both edges of the canonical hole, telling the trimming and checking rules apart, while lock and condition-false cases with bad targets separate fault priority from the no-check rule. A long randomized back-to-back stream then compares every result against a behavioural model.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  localparam logic [1:0] SZ16 = 2'd0;
  localparam logic [1:0] SZ32 = 2'd1;
  localparam logic [1:0] SZ64 = 2'd2;

  localparam logic [7:0] OP_BELOW     = 8'h72;
  localparam logic [7:0] OP_NBELOW    = 8'h73;
  localparam logic [7:0] OP_EQUAL     = 8'h74;
  localparam logic [7:0] OP_NEQUAL    = 8'h75;
  localparam logic [7:0] OP_BELOWEQ   = 8'h76;
  localparam logic [7:0] OP_ABOVE     = 8'h77;
  localparam logic [7:0] OP_LESS      = 8'h7C;
  localparam logic [7:0] OP_GREATEREQ = 8'h7D;
  localparam logic [7:0] OP_LESSEQ    = 8'h7E;
  localparam logic [7:0] OP_GREATER   = 8'h7F;
  localparam logic [7:0] OP_CNTZERO   = 8'hE3;

  // Strobes from the control decision to the result registers.
  typedef struct packed {
    logic load;
    logic takeBranch;
    logic raiseUd;
    logic raiseGp;
    logic flagUnsup;
  } strobe_t;

endpackage

// File: rtl/cbr_ctrl.sv
module cbr_ctrl
  import cbr_pkg::*;
(
  input  logic       inValid,
  input  logic [7:0] opcode,
  input  logic       flagCarry,
  input  logic       flagZero,
  input  logic       flagSign,
  input  logic       flagOverflow,
  input  logic       longMode,
  input  logic [1:0] opSize,
  input  logic [1:0] addrSize,
  input  logic       lockPrefix,
  input  logic       countZero,
  input  logic       targetOk,
  output logic       mask16,
  output strobe_t    strobes
);

  logic condMet;
  logic known;
  logic signMismatch;
  logic badForm;
  logic udHit;
  logic checkedGo;

  assign signMismatch = flagSign ^ flagOverflow;

  always_comb begin
    condMet = 1'b0;
    known   = 1'b1;
    unique case (opcode)
      OP_BELOW:     condMet = flagCarry;
      OP_NBELOW:    condMet = ~flagCarry;
      OP_EQUAL:     condMet = flagZero;
      OP_NEQUAL:    condMet = ~flagZero;
      OP_BELOWEQ:   condMet = flagCarry | flagZero;
      OP_ABOVE:     condMet = ~flagCarry & ~flagZero;
      OP_LESS:      condMet = signMismatch;
      OP_GREATEREQ: condMet = ~signMismatch;
      OP_LESSEQ:    condMet = flagZero | signMismatch;
      OP_GREATER:   condMet = ~flagZero & ~signMismatch;
      OP_CNTZERO:   condMet = countZero;
      default:      known   = 1'b0;
    endcase
  end

  assign mask16 = ~longMode & (opSize == SZ16);

  assign badForm = (opcode == OP_CNTZERO) &
                   ((longMode & (addrSize == SZ16)) | (~longMode & (addrSize == SZ64)));

  assign udHit     = known & (lockPrefix | badForm);
  assign checkedGo = known & ~udHit & condMet;

  always_comb begin
    strobes.load       = inValid;
    strobes.takeBranch = checkedGo & targetOk;
    strobes.raiseUd    = udHit;
    strobes.raiseGp    = checkedGo & ~targetOk;
    strobes.flagUnsup  = ~known;
  end

endmodule

// File: rtl/cbr_datapath.sv
module cbr_datapath
  import cbr_pkg::*;
#(
  parameter int IP_W      = 64,
  parameter int DISP_W    = 8,
  parameter int LIMIT_W   = 32,
  parameter int CANON_MSB = 47
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DISP_W-1:0]  disp,
  input  logic [IP_W-1:0]    curIp,
  input  logic [IP_W-1:0]    countReg,
  input  logic               longMode,
  input  logic [1:0]         addrSize,
  input  logic [LIMIT_W-1:0] csLimit,
  input  logic               mask16,
  input  strobe_t            strobes,
  output logic               countZero,
  output logic               targetOk,
  output logic               outValid,
  output logic               taken,
  output logic [IP_W-1:0]    nextIp,
  output logic               faultUd,
  output logic               faultGp,
  output logic               unsupported
);

  localparam int EXT_W   = IP_W - DISP_W;
  localparam int PAD16_W = IP_W - 16;
  localparam int PADLIM  = IP_W - LIMIT_W;

  logic [IP_W-1:0] dispExt;
  logic [IP_W-1:0] rawTarget;
  logic [IP_W-1:0] target;
  logic            canonical;
  logic            withinLimit;

  assign dispExt   = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign rawTarget = curIp + dispExt;
  assign target    = mask16 ? {{PAD16_W{1'b0}}, rawTarget[15:0]} : rawTarget;

  generate
    if (CANON_MSB < IP_W - 1) begin : g_canon
      logic [IP_W-1-CANON_MSB:0] upper;
      assign upper     = target[IP_W-1:CANON_MSB];
      assign canonical = (&upper) | ~(|upper);
    end else begin : g_nocanon
      assign canonical = 1'b1;
    end
  endgenerate

  assign withinLimit = target <= {{PADLIM{1'b0}}, csLimit};
  assign targetOk    = longMode ? canonical : withinLimit;

  always_comb begin
    unique case (addrSize)
      SZ16:    countZero = ~(|countReg[15:0]);
      SZ32:    countZero = ~(|countReg[31:0]);
      default: countZero = ~(|countReg);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid    <= 1'b0;
      taken       <= 1'b0;
      faultUd     <= 1'b0;
      faultGp     <= 1'b0;
      unsupported <= 1'b0;
      nextIp      <= '0;
    end else begin
      outValid    <= strobes.load;
      taken       <= strobes.load & strobes.takeBranch;
      faultUd     <= strobes.load & strobes.raiseUd;
      faultGp     <= strobes.load & strobes.raiseGp;
      unsupported <= strobes.load & strobes.flagUnsup;
      if (strobes.load) begin
        nextIp <= strobes.takeBranch ? target : curIp;
      end
    end
  end

endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
  import cbr_pkg::*;
#(
  parameter int IP_W      = 64,
  parameter int DISP_W    = 8,
  parameter int LIMIT_W   = 32,
  parameter int CANON_MSB = 47
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic [7:0]         opcode,
  input  logic [DISP_W-1:0]  disp,
  input  logic [IP_W-1:0]    curIp,
  input  logic               flagCarry,
  input  logic               flagZero,
  input  logic               flagSign,
  input  logic               flagOverflow,
  input  logic [IP_W-1:0]    countReg,
  input  logic               longMode,
  input  logic [1:0]         opSize,
  input  logic [1:0]         addrSize,
  input  logic [LIMIT_W-1:0] csLimit,
  input  logic               lockPrefix,
  output logic               outValid,
  output logic               taken,
  output logic [IP_W-1:0]    nextIp,
  output logic               faultUd,
  output logic               faultGp,
  output logic               unsupported
);

  strobe_t strobes;
  logic    mask16;
  logic    countZero;
  logic    targetOk;

  cbr_ctrl u_ctrl (
    .inValid      (inValid),
    .opcode       (opcode),
    .flagCarry    (flagCarry),
    .flagZero     (flagZero),
    .flagSign     (flagSign),
    .flagOverflow (flagOverflow),
    .longMode     (longMode),
    .opSize       (opSize),
    .addrSize     (addrSize),
    .lockPrefix   (lockPrefix),
    .countZero    (countZero),
    .targetOk     (targetOk),
    .mask16       (mask16),
    .strobes      (strobes)
  );

  cbr_datapath #(
    .IP_W      (IP_W),
    .DISP_W    (DISP_W),
    .LIMIT_W   (LIMIT_W),
    .CANON_MSB (CANON_MSB)
  ) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp        (disp),
    .curIp       (curIp),
    .countReg    (countReg),
    .longMode    (longMode),
    .addrSize    (addrSize),
    .csLimit     (csLimit),
    .mask16      (mask16),
    .strobes     (strobes),
    .countZero   (countZero),
    .targetOk    (targetOk),
    .outValid    (outValid),
    .taken       (taken),
    .nextIp      (nextIp),
    .faultUd     (faultUd),
    .faultGp     (faultGp),
    .unsupported (unsupported)
  );

endmodule

// File: rtl/cbr_checker.sv
module cbr_checker #(
  parameter int IP_W    = 64,
  parameter int DISP_W  = 8,
  parameter int LIMIT_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inValid,
  input logic [7:0]         opcode,
  input logic [DISP_W-1:0]  disp,
  input logic [IP_W-1:0]    curIp,
  input logic               flagCarry,
  input logic               flagZero,
  input logic               flagSign,
  input logic               flagOverflow,
  input logic [IP_W-1:0]    countReg,
  input logic               longMode,
  input logic [1:0]         opSize,
  input logic [1:0]         addrSize,
  input logic [LIMIT_W-1:0] csLimit,
  input logic               lockPrefix,
  input logic               outValid,
  input logic               taken,
  input logic [IP_W-1:0]    nextIp,
  input logic               faultUd,
  input logic               faultGp,
  input logic               unsupported
);

  assert_valid_delay_R12: assert property (@(posedge clk) disable iff (!rst_n)
    outValid == $past(inValid));

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !outValid |-> (!taken && !faultUd && !faultGp && !unsupported));

  assert_ud_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    faultUd |-> (!taken && !faultGp));

  assert_gp_not_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    faultGp |-> !taken);

  assert_lock_ud_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && lockPrefix && opcode == 8'h74) |=> faultUd);

  assert_unsup_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    unsupported |-> (!taken && !faultUd && !faultGp));

  assert_hold_ip_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !taken) |-> (nextIp == $past(curIp)));

endmodule

bind cbr_unit cbr_checker #(
  .IP_W    (IP_W),
  .DISP_W  (DISP_W),
  .LIMIT_W (LIMIT_W)
) u_chk (.*);

// File: tb/tb_cbr_unit.sv
module tb_cbr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [7:0]  disp = '0;
  logic [63:0] curIp = '0;
  logic        flagCarry = 1'b0, flagZero = 1'b0, flagSign = 1'b0, flagOverflow = 1'b0;
  logic [63:0] countReg = '0;
  logic        longMode = 1'b0;
  logic [1:0]  opSize = '0, addrSize = '0;
  logic [31:0] csLimit = '0;
  logic        lockPrefix = 1'b0;
  logic        outValid, taken, faultUd, faultGp, unsupported;
  logic [63:0] nextIp;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  cbr_unit dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opcode(opcode), .disp(disp),
    .curIp(curIp), .flagCarry(flagCarry), .flagZero(flagZero), .flagSign(flagSign),
    .flagOverflow(flagOverflow), .countReg(countReg), .longMode(longMode),
    .opSize(opSize), .addrSize(addrSize), .csLimit(csLimit), .lockPrefix(lockPrefix),
    .outValid(outValid), .taken(taken), .nextIp(nextIp), .faultUd(faultUd),
    .faultGp(faultGp), .unsupported(unsupported)
  );

  // Behavioural reference: one result per request.
  task automatic model(output bit eTaken, output bit eUd, output bit eGp,
                       output bit eUns, output logic [63:0] eIp);
    bit cond = 0;
    bit evaluated = 1;
    longint signed offs;
    logic [63:0] tgt;
    bit bad;
    eTaken = 0; eUd = 0; eGp = 0; eUns = 0; eIp = curIp;
    case (opcode)
      8'h72: cond = flagCarry;
      8'h73: cond = !flagCarry;
      8'h74: cond = flagZero;
      8'h75: cond = !flagZero;
      8'h76: cond = flagCarry || flagZero;
      8'h77: cond = !flagCarry && !flagZero;
      8'h7C: cond = flagSign != flagOverflow;
      8'h7D: cond = flagSign == flagOverflow;
      8'h7E: cond = flagZero || (flagSign != flagOverflow);
      8'h7F: cond = !flagZero && (flagSign == flagOverflow);
      8'hE3: begin
        if (addrSize == 0)      cond = (countReg % 64'h1_0000) == 0;
        else if (addrSize == 1) cond = (countReg % 64'h1_0000_0000) == 0;
        else                    cond = countReg == 0;
      end
      default: evaluated = 0;
    endcase
    if (!evaluated) begin
      eUns = 1;
      return;
    end
    if (lockPrefix || (opcode == 8'hE3 &&
        ((longMode && addrSize == 0) || (!longMode && addrSize == 2)))) begin
      eUd = 1;
      return;
    end
    if (!cond) return;
    offs = longint'($signed(disp));
    tgt = curIp + offs;
    if (!longMode && opSize == 0) tgt = tgt % 64'h1_0000;
    if (longMode) bad = !(tgt < 64'h0000_8000_0000_0000 || tgt >= 64'hFFFF_8000_0000_0000);
    else          bad = tgt > csLimit;
    if (bad) eGp = 1;
    else begin
      eTaken = 1;
      eIp = tgt;
    end
  endtask

  task automatic send(input string tag, input logic [7:0] op, input logic [7:0] d,
                      input logic [63:0] ip, input logic [3:0] fl, input logic [63:0] cnt,
                      input logic lm, input logic [1:0] os, input logic [1:0] as,
                      input logic [31:0] lim, input logic lk);
    bit eT, eU, eG, eN;
    logic [63:0] eI;
    opcode = op; disp = d; curIp = ip;
    {flagCarry, flagZero, flagSign, flagOverflow} = fl;
    countReg = cnt; longMode = lm; opSize = os; addrSize = as; csLimit = lim;
    lockPrefix = lk; inValid = 1'b1;
    model(eT, eU, eG, eN, eI);
    @(negedge clk);
    inValid = 1'b0;
    checks++;
    if (outValid !== 1'b1 || taken !== eT || faultUd !== eU || faultGp !== eG ||
        unsupported !== eN || nextIp !== eI) begin
      errors++;
      $display("FAIL %s op=%h: actual v=%b t=%b ud=%b gp=%b un=%b ip=%h expected v=1 t=%b ud=%b gp=%b un=%b ip=%h",
               tag, op, outValid, taken, faultUd, faultGp, unsupported, nextIp,
               eT, eU, eG, eN, eI);
    end
  endtask

  task automatic idleCheck(input string tag);
    inValid = 1'b0;
    @(negedge clk);
    checks++;
    if (outValid !== 1'b0 || taken !== 1'b0 || faultUd !== 1'b0 ||
        faultGp !== 1'b0 || unsupported !== 1'b0) begin
      errors++;
      $display("FAIL %s idle: actual v=%b t=%b ud=%b gp=%b un=%b expected all 0",
               tag, outValid, taken, faultUd, faultGp, unsupported);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish();
  end

  localparam logic [63:0] LO = 64'h1000;
  localparam logic [31:0] BIG = 32'hFFFF_FFFF;

  initial begin
    repeat (3) @(negedge clk);
    idleCheck("R12 reset");
    rst_n = 1'b1;
    idleCheck("R12 post-reset");

    // flags order: {carry, zero, sign, overflow}
    send("R1 jb carry", 8'h72, 8'h10, LO, 4'b1000, 0, 1, 2, 2, BIG, 0);
    send("R1 jae carry", 8'h73, 8'h10, LO, 4'b1000, 0, 1, 2, 2, BIG, 0);
    send("R1 je", 8'h74, 8'h10, LO, 4'b0100, 0, 1, 2, 2, BIG, 0);
    send("R1 jne", 8'h75, 8'h10, LO, 4'b0100, 0, 1, 2, 2, BIG, 0);
    send("R1 jbe zero", 8'h76, 8'h10, LO, 4'b0100, 0, 1, 2, 2, BIG, 0);
    send("R1 ja clear", 8'h77, 8'h10, LO, 4'b0000, 0, 1, 2, 2, BIG, 0);
    send("R1 ja carry", 8'h77, 8'h10, LO, 4'b1000, 0, 1, 2, 2, BIG, 0);
    send("R2 jl", 8'h7C, 8'h10, LO, 4'b0010, 0, 1, 2, 2, BIG, 0);
    send("R2 jge", 8'h7D, 8'h10, LO, 4'b0010, 0, 1, 2, 2, BIG, 0);
    send("R2 jge eq", 8'h7D, 8'h10, LO, 4'b0011, 0, 1, 2, 2, BIG, 0);
    send("R2 jle zero", 8'h7E, 8'h10, LO, 4'b0100, 0, 1, 2, 2, BIG, 0);
    send("R2 jg", 8'h7F, 8'h10, LO, 4'b0011, 0, 1, 2, 2, BIG, 0);
    send("R2 jg zero", 8'h7F, 8'h10, LO, 4'b0111, 0, 1, 2, 2, BIG, 0);

    send("R3 cx", 8'hE3, 8'h10, LO, 4'b0100, 64'h1_0000, 0, 1, 0, BIG, 0);
    send("R3 ecx", 8'hE3, 8'h10, LO, 4'b0100, 64'h1_0000, 0, 1, 1, BIG, 0);
    send("R3 ecx hi", 8'hE3, 8'h10, LO, 4'b0000, 64'h1_0000_0000, 1, 2, 1, BIG, 0);
    send("R3 rcx", 8'hE3, 8'h10, LO, 4'b0000, 64'h1_0000_0000, 1, 2, 2, BIG, 0);
    send("R3 rcx zero", 8'hE3, 8'h10, LO, 4'b0000, 0, 1, 2, 2, BIG, 0);

    send("R4 long a16", 8'hE3, 8'h10, LO, 4'b0000, 0, 1, 2, 0, BIG, 0);
    send("R4 legacy a64", 8'hE3, 8'h10, LO, 4'b0000, 0, 0, 1, 2, BIG, 0);

    send("R5 back", 8'h74, 8'h80, LO, 4'b0100, 0, 1, 2, 2, BIG, 0);
    send("R5 fwd", 8'h74, 8'h7F, 64'hFFFF_FFFF_0000_0000, 4'b0100, 0, 1, 2, 2, BIG, 0);

    send("R6 wrap16", 8'h74, 8'h20, 64'h1_FFF0, 4'b0100, 0, 0, 0, 1, BIG, 0);
    send("R6 long no mask", 8'h74, 8'h20, 64'hFFF0, 4'b0100, 0, 1, 0, 2, BIG, 0);

    send("R7 over", 8'h74, 8'h20, 64'hF0, 4'b0100, 0, 0, 1, 1, 32'h10F, 0);
    send("R7 at", 8'h74, 8'h1F, 64'hF0, 4'b0100, 0, 0, 1, 1, 32'h10F, 0);

    send("R8 up", 8'h74, 8'h20, 64'h0000_7FFF_FFFF_FFF0, 4'b0100, 0, 1, 2, 2, BIG, 0);
    send("R8 down", 8'h74, 8'hE0, 64'hFFFF_8000_0000_0010, 4'b0100, 0, 1, 2, 2, BIG, 0);
    send("R8 edge ok", 8'h74, 8'h0F, 64'h0000_7FFF_FFFF_FFF0, 4'b0100, 0, 1, 2, 2, BIG, 0);

    send("R9 lock", 8'h74, 8'h10, LO, 4'b0100, 0, 0, 1, 1, BIG, 1);
    send("R9 lock over gp", 8'h74, 8'h20, 64'h0000_7FFF_FFFF_FFF0, 4'b0100, 0, 1, 2, 2, BIG, 1);

    send("R10 false no gp", 8'h75, 8'h20, 64'h0000_7FFF_FFFF_FFF0, 4'b0100, 0, 1, 2, 2, BIG, 0);
    send("R10 false limit", 8'h72, 8'h20, 64'hF0, 4'b0000, 0, 0, 1, 1, 32'h10F, 0);

    send("R11 jo", 8'h70, 8'h10, LO, 4'b1111, 0, 1, 2, 2, BIG, 0);
    send("R11 jp lock", 8'h7A, 8'h10, LO, 4'b1111, 0, 1, 2, 2, BIG, 1);
    idleCheck("R12 gap");

    for (int i = 0; i < 600; i++) begin
      logic [7:0] ops [14];
      logic [7:0] op;
      logic [63:0] ip, cnt;
      logic lm;
      ops = '{8'h70, 8'h71, 8'h72, 8'h73, 8'h74, 8'h75, 8'h76, 8'h77,
              8'h7B, 8'h7C, 8'h7D, 8'h7E, 8'h7F, 8'hE3};
      op = ops[$urandom_range(0, 13)];
      lm = 1'($urandom_range(0, 1));
      if (lm) ip = ($urandom_range(0, 1) != 0) ? 64'h0000_7FFF_FFFF_FF80 + 64'($urandom_range(0, 255))
                                               : 64'hFFFF_7FFF_FFFF_FF80 + 64'($urandom_range(0, 255));
      else    ip = {32'h0, 32'($urandom())};
      case ($urandom_range(0, 3))
        0: cnt = 0;
        1: cnt = 64'h1_0000;
        2: cnt = 64'h1_0000_0000;
        default: cnt = {32'($urandom()), 32'($urandom())};
      endcase
      send("R12 stream", op, 8'($urandom()), ip, 4'($urandom()), cnt, lm,
           2'($urandom_range(0, 2)), 2'($urandom_range(0, 2)),
           ($urandom_range(0, 1) != 0) ? BIG : ip[31:0] + 32'($urandom_range(0, 256)) - 32'd128,
           ($urandom_range(0, 15) == 0));
      if (i % 50 == 7) idleCheck("R12 stream idle");
    end

    finish();
  end

endmodule